// File: doc/BRIEF.md
# Idle-Slot ROM Prefetch Arbiter

This block lets a coprocessor read a cartridge ROM that it shares with a host CPU. The host always has priority. The coprocessor uses the ROM only in master-clock cycles where both active-low host strobes (read and write) are high. The host program first writes a 24-bit start address into three byte registers. It then writes to a trigger register. That write arms a fixed six-read startup burst:

1. one read for the header and current data byte,
2. one read for the next data byte,
3. four reads into a 4-entry FIFO.

A read is committed only after three consecutive idle master cycles. If either strobe falls earlier, the read is abandoned and the same address is tried again in the next idle gap.

While a read is in flight, the block drives the ROM address, chip-select and output-enable itself. In every other cycle these pins follow the host's decoded ROM access. A ready flag tells the downstream decompressor that the burst has finished. The decompressor drains the FIFO through a simple pop port.

Top module: `rom_prefetch_arb`

## Requirements
- R1: After reset, `ready_o` is 0, `fifo_empty_o` is 1, no coprocessor read is in progress, and the ROM pins follow the host.
- R2: A completed host write sets a register. The write is complete on the cycle `host_wr_ni` returns high, and it uses the address and data seen during its last low cycle. Host address bits [15:0] select the register: 0x4802 sets base bits [7:0], 0x4803 sets bits [15:8], 0x4804 sets bits [23:16]. A completed write to 0x4801 starts a burst from the base address, whatever its data.
- R3: A coprocessor read drives the ROM only in cycles where `host_rd_ni` and `host_wr_ni` are both 1. In those cycles `rom_cs_no` and `rom_oe_no` are 0 and `rom_addr_o` carries the fetch address.
- R4: A read commits only at the end of the third consecutive idle cycle of a pending burst. It captures `rom_data_i` at that clock edge. An idle gap shorter than three cycles never commits anything.
- R5: A strobe falling during a read abandons that read. Nothing is stored, and the same address is fetched again later.
- R6: The first committed read goes to `hdr_data_o`, the second to `nxt_data_o`, and reads three to six are pushed into the FIFO in order. The fetch address rises by one after each commit, carrying across byte boundaries.
- R7: `ready_o` rises after the sixth commit. After that, no ROM read is stolen until the next trigger.
- R8: The FIFO holds 4 bytes. `fifo_data_o` shows the oldest byte. `fifo_rd_i` high while the FIFO is not empty pops one byte per cycle. A pop while empty has no effect.
- R9: Outside a coprocessor read, `rom_addr_o` equals `host_addr_i`, `rom_cs_no` is the inverse of `host_rom_sel_i`, and `rom_oe_no` is 0 only when `host_rom_sel_i` is 1 and `host_rd_ni` is 0.
- R10: A trigger during a burst restarts it from the current base. The FIFO is cleared, `ready_o` drops, and the read in flight is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_rd_ni | input | 1 | Host read strobe, active low |
| host_wr_ni | input | 1 | Host write strobe, active low |
| host_addr_i | input | 24 | Host address bus |
| host_data_i | input | 8 | Host write data |
| host_rom_sel_i | input | 1 | Host address decodes to ROM |
| rom_data_i | input | 8 | ROM read data |
| rom_addr_o | output | 24 | ROM address |
| rom_cs_no | output | 1 | ROM chip select, active low |
| rom_oe_no | output | 1 | ROM output enable, active low |
| hdr_data_o | output | 8 | Header and current data byte |
| nxt_data_o | output | 8 | Next data byte |
| fifo_rd_i | input | 1 | FIFO pop request |
| fifo_data_o | output | 8 | Oldest FIFO byte |
| fifo_empty_o | output | 1 | FIFO empty |
| ready_o | output | 1 | Six-read burst complete |

## Verification
The ROM pins are combinational. The bench therefore checks stealing and pass-through one time unit after the falling edge on which the strobes change. A trigger takes effect at the rising edge after `host_wr_ni` goes high, so the first steal is expected one full cycle after the write task returns. Each commit lands three idle cycles later. Result bytes and `ready_o` are checked only after enough idle cycles for all six commits to land. Gaps of two idle cycles are checked to leave `ready_o` low and the FIFO empty. The scoreboard compares each popped FIFO byte with the head of its queue at the falling edge of the pop cycle, before the rising edge that removes the byte.

// File: rtl/rpa_pkg.sv
package rpa_pkg;
  localparam int unsigned NUM_SLOTS  = 6;
  localparam int unsigned SLOT_W     = 3;
  localparam int unsigned SLOT_HDR   = 0;
  localparam int unsigned SLOT_NXT   = 1;
  localparam int unsigned SLOT_FIFO0 = 2;

  typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/rpa_host_regs.sv
module rpa_host_regs #(
  parameter int unsigned HOST_AW   = 24,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 24,
  parameter logic [15:0] TRIG_ADDR = 16'h4801,
  parameter logic [15:0] BASE_REG  = 16'h4802
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_ni,
  input  logic [HOST_AW-1:0] addr_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic               trig_o,
  output logic [ADDR_W-1:0]  base_o
);
  localparam int unsigned NBYTES = ADDR_W / DATA_W;

  logic              wr_q;
  logic [15:0]       wa_q;
  logic [DATA_W-1:0] wd_q;
  logic              wr_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= 1'b1;
      wa_q <= '0;
      wd_q <= '0;
    end else begin
      wr_q <= wr_ni;
      if (!wr_ni) begin
        wa_q <= addr_i[15:0];
        wd_q <= data_i;
      end
    end
  end

  // write takes effect on the cycle the strobe releases
  assign wr_end = wr_ni & ~wr_q;
  assign trig_o = wr_end && (wa_q == TRIG_ADDR);

  for (genvar b = 0; b < NBYTES; b++) begin : g_base
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_o[b*DATA_W +: DATA_W] <= '0;
      end else if (wr_end && (wa_q == BASE_REG + 16'(b))) begin
        base_o[b*DATA_W +: DATA_W] <= wd_q;
      end
    end
  end
endmodule

// File: rtl/rpa_seq.sv
module rpa_seq
  import rpa_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned RD_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_idle_i,
  input  logic              trig_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              steal_o,
  output logic              commit_o,
  output slot_t             slot_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              done_o
);
  localparam int unsigned CNT_W = (RD_CYC > 1) ? $clog2(RD_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RD_CYC - 1);

  logic             armed_q;
  slot_t            slot_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic             pending;

  assign pending  = armed_q && (slot_q < slot_t'(NUM_SLOTS));
  assign steal_o  = pending & host_idle_i;
  assign commit_o = steal_o && (cnt_q == CNT_LAST) && !trig_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      slot_q  <= '0;
      cnt_q   <= '0;
      addr_q  <= '0;
    end else if (trig_i) begin
      armed_q <= 1'b1;
      slot_q  <= '0;
      cnt_q   <= '0;
      addr_q  <= base_i;
    end else if (commit_o) begin
      slot_q  <= slot_q + slot_t'(1);
      cnt_q   <= '0;
      addr_q  <= addr_q + ADDR_W'(1);
    end else if (steal_o) begin
      cnt_q   <= cnt_q + CNT_W'(1);
    end else begin
      cnt_q   <= '0; // abandoned or not started
    end
  end

  assign slot_o       = slot_q;
  assign fetch_addr_o = addr_q;
  assign done_o       = armed_q && (slot_q == slot_t'(NUM_SLOTS));
endmodule

// File: rtl/rpa_fifo.sv
module rpa_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic [$clog2(DEPTH):0] level_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned LVL_W = PTR_W + 1;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wp_q, rp_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              do_push, do_pop;

  assign empty_o = (lvl_q == '0);
  assign do_pop  = pop_i & ~empty_o;
  assign do_push = push_i && (lvl_q != LVL_W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + PTR_W'(1);
      if (do_pop)  rp_q <= (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + PTR_W'(1);
      lvl_q <= lvl_q + LVL_W'(do_push) - LVL_W'(do_pop);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_mem
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[i] <= '0;
      else if (do_push && !clr_i && (wp_q == PTR_W'(i))) mem_q[i] <= push_data_i;
    end
  end

  assign head_o  = mem_q[rp_q];
  assign level_o = lvl_q;
endmodule

// File: rtl/rom_prefetch_arb.sv
module rom_prefetch_arb
  import rpa_pkg::*;
#(
  parameter int unsigned HOST_AW    = 24,
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned RD_CYC     = 3,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter logic [15:0] TRIG_ADDR  = 16'h4801,
  parameter logic [15:0] BASE_REG   = 16'h4802
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_rd_ni,
  input  logic               host_wr_ni,
  input  logic [HOST_AW-1:0] host_addr_i,
  input  logic [DATA_W-1:0]  host_data_i,
  input  logic               host_rom_sel_i,
  input  logic [DATA_W-1:0]  rom_data_i,
  output logic [ADDR_W-1:0]  rom_addr_o,
  output logic               rom_cs_no,
  output logic               rom_oe_no,
  output logic [DATA_W-1:0]  hdr_data_o,
  output logic [DATA_W-1:0]  nxt_data_o,
  input  logic               fifo_rd_i,
  output logic [DATA_W-1:0]  fifo_data_o,
  output logic               fifo_empty_o,
  output logic               ready_o
);
  localparam int unsigned LVL_W = $clog2(FIFO_DEPTH) + 1;

  logic              trig;
  logic [ADDR_W-1:0] base;
  logic              steal, commit;
  slot_t             slot;
  logic [ADDR_W-1:0] fetch_addr;
  logic [LVL_W-1:0]  fifo_level;
  logic              push;
  logic [DATA_W-1:0] hdr_q, nxt_q;

  rpa_host_regs #(
    .HOST_AW(HOST_AW), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .TRIG_ADDR(TRIG_ADDR), .BASE_REG(BASE_REG)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_ni(host_wr_ni),
    .addr_i(host_addr_i), .data_i(host_data_i),
    .trig_o(trig), .base_o(base)
  );

  rpa_seq #(.ADDR_W(ADDR_W), .RD_CYC(RD_CYC)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .host_idle_i(host_rd_ni & host_wr_ni),
    .trig_i(trig), .base_i(base),
    .steal_o(steal), .commit_o(commit), .slot_o(slot),
    .fetch_addr_o(fetch_addr), .done_o(ready_o)
  );

  assign push = commit && (slot >= slot_t'(SLOT_FIFO0));

  rpa_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(trig),
    .push_i(push), .push_data_i(rom_data_i), .pop_i(fifo_rd_i),
    .head_o(fifo_data_o), .empty_o(fifo_empty_o), .level_o(fifo_level)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_q <= '0;
      nxt_q <= '0;
    end else if (commit) begin
      if (slot == slot_t'(SLOT_HDR)) hdr_q <= rom_data_i;
      if (slot == slot_t'(SLOT_NXT)) nxt_q <= rom_data_i;
    end
  end

  assign hdr_data_o = hdr_q;
  assign nxt_data_o = nxt_q;

  // steal overrides host ROM decode
  assign rom_addr_o = steal ? fetch_addr : ADDR_W'(host_addr_i);
  assign rom_cs_no  = steal ? 1'b0 : ~host_rom_sel_i;
  assign rom_oe_no  = steal ? 1'b0 : ~(host_rom_sel_i & ~host_rd_ni);
endmodule

// File: rtl/rpa_checker.sv
module rpa_checker #(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned LVL_W      = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_rd_ni,
  input logic              host_wr_ni,
  input logic              steal_i,
  input logic              commit_i,
  input logic [ADDR_W-1:0] fetch_addr_i,
  input logic              ready_i,
  input logic [LVL_W-1:0]  level_i
);
  // R3
  idle_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_rd_ni || !host_wr_ni) |-> !steal_i);

  // R4
  full_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> ($past(steal_i) && $past(steal_i, 2)));

  // R6
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> (fetch_addr_i == $past(fetch_addr_i) + ADDR_W'(1)));

  // R7
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |-> !steal_i);

  // R8
  fifo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i <= LVL_W'(FIFO_DEPTH));
endmodule

bind rom_prefetch_arb rpa_checker #(
  .ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .host_rd_ni(host_rd_ni), .host_wr_ni(host_wr_ni),
  .steal_i(steal), .commit_i(commit), .fetch_addr_i(fetch_addr),
  .ready_i(ready_o), .level_i(fifo_level)
);

// File: tb/rom_prefetch_arb_bench.sv
module rom_prefetch_arb_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_rd_ni = 1'b1, host_wr_ni = 1'b1;
  logic [23:0] host_addr_i = '0;
  logic [7:0]  host_data_i = '0;
  logic        host_rom_sel_i = 1'b0;
  logic [7:0]  rom_data_i;
  logic [23:0] rom_addr_o;
  logic        rom_cs_no, rom_oe_no;
  logic [7:0]  hdr_data_o, nxt_data_o, fifo_data_o;
  logic        fifo_rd_i = 1'b0;
  logic        fifo_empty_o, ready_o;

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];

  always #2 clk_i = ~clk_i;

  function automatic logic [7:0] rom_byte(logic [23:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ {a[23:20], a[19:16]} ^ 8'h5A;
  endfunction

  assign rom_data_i = rom_byte(rom_addr_o);

  rom_prefetch_arb u_rom_prefetch_arb (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    host_addr_i = {8'h00, a}; host_data_i = d; host_rom_sel_i = 1'b0; host_wr_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    host_wr_ni = 1'b1;
  endtask

  task automatic set_base(input logic [23:0] b);
    host_write(16'h4802, b[7:0]);
    host_write(16'h4803, b[15:8]);
    host_write(16'h4804, b[23:16]);
  endtask

  // host bus cycle: idle_n idle clocks then busy_n clocks of ROM read
  task automatic host_cycle(input int idle_n, input int busy_n);
    host_rd_ni = 1'b1; host_rom_sel_i = 1'b0;
    repeat (idle_n) @(negedge clk_i);
    host_addr_i = 24'hC08001; host_rom_sel_i = 1'b1; host_rd_ni = 1'b0;
    repeat (busy_n) @(negedge clk_i);
    host_rd_ni = 1'b1; host_rom_sel_i = 1'b0;
  endtask

  task automatic check_burst(input logic [23:0] b, input string req);
    chk(ready_o === 1'b1, req, ready_o, 1);
    chk(hdr_data_o === rom_byte(b), req, hdr_data_o, rom_byte(b));
    chk(nxt_data_o === rom_byte(b + 24'd1), req, nxt_data_o, rom_byte(b + 24'd1));
    for (int i = 2; i < 6; i++) exp_q.push_back(rom_byte(b + 24'(i)));
  endtask

  task automatic drain(input string req);
    while (!fifo_empty_o) begin
      fifo_rd_i = 1'b1;
      @(negedge clk_i);
    end
    fifo_rd_i = 1'b0;
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    #1;
    if (fifo_rd_i && !fifo_empty_o) begin
      if (exp_q.size() == 0) chk(1'b0, "R8 extra pop", fifo_data_o, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(fifo_data_o === e, "R6/R8 fifo order", fifo_data_o, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    // R1
    chk(ready_o === 1'b0, "R1 ready", ready_o, 0);
    chk(fifo_empty_o === 1'b1, "R1 empty", fifo_empty_o, 1);
    chk(rom_cs_no === 1'b1 && rom_oe_no === 1'b1, "R1 pins", {rom_cs_no, rom_oe_no}, 2'b11);

    // R9 pass-through host read
    @(negedge clk_i);
    host_addr_i = 24'hC08001; host_rom_sel_i = 1'b1; host_rd_ni = 1'b0; #1;
    chk(rom_addr_o === 24'hC08001 && !rom_cs_no && !rom_oe_no, "R9 host read", rom_addr_o, 24'hC08001);
    @(negedge clk_i);
    host_rd_ni = 1'b1; #1;
    chk(rom_cs_no === 1'b0 && rom_oe_no === 1'b1, "R9 sel no rd", {rom_cs_no, rom_oe_no}, 2'b01);
    host_rom_sel_i = 1'b0;

    // R2 R3 R4 R6 R7: full burst with carry across byte boundary
    set_base(24'h1234FE);
    host_write(16'h4801, 8'hAA);
    @(negedge clk_i); #1;
    chk(rom_addr_o === 24'h1234FE && !rom_cs_no && !rom_oe_no, "R3 steal addr", rom_addr_o, 24'h1234FE);
    repeat (25) @(negedge clk_i);
    #1;
    check_burst(24'h1234FE, "R6 burst1");
    chk(rom_cs_no === 1'b1, "R7 no steal after ready", rom_cs_no, 1);
    drain("R8 drain1");

    // R8 pop while empty
    fifo_rd_i = 1'b1;
    @(negedge clk_i);
    fifo_rd_i = 1'b0; #1;
    chk(fifo_empty_o === 1'b1 && ready_o === 1'b1, "R8 pop empty", fifo_empty_o, 1);

    // R4 R5: short idle gaps never commit
    set_base(24'h00FFFD);
    host_write(16'h4801, 8'h00);
    for (int k = 0; k < 6; k++) host_cycle(2, 4);
    #1;
    chk(ready_o === 1'b0 && fifo_empty_o === 1'b1, "R4 short gap", {ready_o, fifo_empty_o}, 2'b01);
    host_rd_ni = 1'b1;
    repeat (25) @(negedge clk_i);
    #1;
    check_burst(24'h00FFFD, "R5 retry");
    drain("R5 drain");

    // slow host: 3 idle of 8 per cycle, one read per gap
    set_base(24'h400010);
    host_write(16'h4801, 8'h00);
    for (int k = 0; k < 4; k++) host_cycle(3, 5);
    #1;
    chk(ready_o === 1'b0, "R4 slow partial", ready_o, 0);
    for (int k = 0; k < 4; k++) host_cycle(3, 5);
    #1;
    check_burst(24'h400010, "R4 slow full");
    drain("R4 slow drain");

    // R10 retrigger mid-burst
    set_base(24'h001000);
    host_write(16'h4801, 8'h00);
    repeat (12) @(negedge clk_i);
    set_base(24'h2000F0);
    host_write(16'h4801, 8'h00);
    @(negedge clk_i); #1;
    chk(ready_o === 1'b0 && fifo_empty_o === 1'b1, "R10 restart clear", {ready_o, fifo_empty_o}, 2'b01);
    repeat (25) @(negedge clk_i);
    #1;
    check_burst(24'h2000F0, "R10 new base");
    drain("R10 drain");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule